// File: doc/BRIEF.md
# Windowed Register File

This block is the integer register file of a processor core that keeps one register window per active subroutine. It holds 136 registers of 32 bits. Eight of them are globals, visible from every window. The other 128 form a circular bank of eight overlapping windows. An instruction names a register with a 5-bit architectural number. A current-window pointer turns that number into a physical register index.

Two combinational read ports and one clocked write port serve the pipeline. A save strobe moves the pointer to a fresh window for a called routine, and a restore strobe returns it to the caller. Neighbouring windows share eight registers, so arguments and results pass between caller and callee without any copying. Windows marked unusable in an invalid-window mask block the move and raise an overflow or underflow flag instead. Spill and fill handling is left to the surrounding trap logic.

Top module: `winreg_file`

## Requirements
- R1: After reset the window pointer is 0, overflow and underflow are low, and every register reads zero.
- R2: Architectural registers 1 to 7 are globals. They name the same physical register in every window.
- R3: Architectural registers 16 to 23 are the locals and are private to their window. After a save they read as a separate set. After a restore the caller's locals still hold their old values.
- R4: Registers 8 to 15 (outs) of window w are physically registers 24 to 31 (ins) of window w-1 mod 8, which is the window that a save from w enters.
- R5: Register 0 always reads zero, and a write to it has no effect.
- R6: A save that is not blocked sets the pointer to pointer-1 mod 8. A restore that is not blocked sets it to pointer+1 mod 8. Both take effect at the clock edge.
- R7: When save_req is high and bit (pointer-1 mod 8) of the invalid mask is set, overflow is high in the same cycle and the pointer does not change.
- R8: When a restore is requested and bit (pointer+1 mod 8) of the invalid mask is set, underflow is high in the same cycle and the pointer does not change.
- R9: When save_req and restore_req are high together, the save is carried out, the restore is ignored, and underflow stays low.
- R10: Reads are combinational. A write shows up only after the clock edge, and it is placed through the pointer as it was before any save or restore in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 5 | Architectural register number for read port A |
| rd_a_data | output | 32 | Read port A data (combinational) |
| rd_b_idx | input | 5 | Architectural register number for read port B |
| rd_b_data | output | 32 | Read port B data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Architectural register number for the write |
| wr_data | input | 32 | Write data |
| save_req | input | 1 | Move to a new window (pointer-1) |
| restore_req | input | 1 | Return to the caller window (pointer+1) |
| inval_mask | input | 8 | One bit per window; a set bit marks the window unusable |
| cur_win | output | 3 | Current window pointer |
| overflow | output | 1 | A save targeted a masked window (same cycle) |
| underflow | output | 1 | A restore targeted a masked window (same cycle) |

## Verification
A table-driven pass writes distinct patterns into the globals, outs, locals and ins of one window. It then moves through save and restore and reads every group back. Each group has its own value, so the readback tells whether a register was shared, kept private or aliased to the wrong neighbour in either direction. Directed tests cover:
- an eight-save lap around the ring and the wrap between windows 0 and 7;
- masked targets for both flags;
- a save and a restore in the same cycle;
- a write in the same cycle as a save;
- a write to register 0.

Together these separate errors in the pointer arithmetic from errors in the address mapping.

// File: rtl/winreg_pkg.sv
package winreg_pkg;
  localparam int ARCH_W   = 5;   // architectural register number width
  localparam int GRP_SIZE = 8;   // registers per group (globals, outs, locals, ins)
  localparam int NEW_PER_WIN = 2 * GRP_SIZE;  // locals + ins added per window

  typedef logic [ARCH_W-1:0] arch_idx_t;

  // Architectural numbers below GRP_SIZE are globals.
  function automatic logic is_global(arch_idx_t a);
    return a < arch_idx_t'(GRP_SIZE);
  endfunction
endpackage

// File: rtl/winreg_win_ctl.sv
module winreg_win_ctl #(
  parameter int NWIN = 8,
  localparam int WP_W = $clog2(NWIN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            save_req,
  input  logic            restore_req,
  input  logic [NWIN-1:0] inval_mask,
  output logic [WP_W-1:0] cwp,
  output logic            overflow,
  output logic            underflow
);
  // Named events for the assertions
  logic [WP_W-1:0] save_tgt;
  logic [WP_W-1:0] restore_tgt;
  logic            save_cmd;
  logic            restore_cmd;
  logic            save_ok;
  logic            restore_ok;

  // Ring arithmetic: NWIN is a power of two, so wrap is natural.
  function automatic logic [WP_W-1:0] ring_step(logic [WP_W-1:0] p, logic down);
    return down ? p - 1'b1 : p + 1'b1;
  endfunction

  assign save_tgt    = ring_step(cwp, 1'b1);
  assign restore_tgt = ring_step(cwp, 1'b0);
  assign save_cmd    = save_req;
  assign restore_cmd = restore_req && !save_req;     // save wins
  assign overflow    = save_cmd && inval_mask[save_tgt];
  assign underflow   = restore_cmd && inval_mask[restore_tgt];
  assign save_ok     = save_cmd && !overflow;
  assign restore_ok  = restore_cmd && !underflow;

  always_ff @(posedge clk) begin
    if (!rst_n)          cwp <= '0;
    else if (save_ok)    cwp <= save_tgt;
    else if (restore_ok) cwp <= restore_tgt;
  end

  AST_SAVE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && !overflow) |=> cwp == $past(cwp) - 1'b1);  // R6
  AST_RESTORE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_req && !save_req && !underflow) |=> cwp == $past(cwp) + 1'b1);  // R6
  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> $stable(cwp));  // R7
  AST_UNF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> $stable(cwp));  // R8
  AST_BOTH_SAVE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && restore_req) |-> !underflow);  // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!save_req && !restore_req) |=> $stable(cwp));  // R6
endmodule

// File: rtl/winreg_addr_map.sv
module winreg_addr_map
  import winreg_pkg::*;
#(
  parameter int NWIN = 8,
  localparam int WP_W   = $clog2(NWIN),
  localparam int BANK_W = $clog2(NWIN * NEW_PER_WIN),
  localparam int PHYS_W = $clog2(GRP_SIZE + NWIN * NEW_PER_WIN)
) (
  input  logic [WP_W-1:0]   win,
  input  arch_idx_t         arch,
  output logic [PHYS_W-1:0] phys
);
  logic [BANK_W-1:0] win_base;
  logic [BANK_W-1:0] rot;

  // Outs sit at window base, locals next, ins spill into the next
  // window's base, so outs(w) == ins(w-1).
  assign win_base = BANK_W'(win) << $clog2(NEW_PER_WIN);

  always_comb begin
    rot = win_base + BANK_W'(arch - arch_idx_t'(GRP_SIZE));
    if (is_global(arch)) phys = PHYS_W'(arch);
    else                 phys = PHYS_W'(GRP_SIZE) + PHYS_W'(rot);
  end
endmodule

// File: rtl/winreg_storage.sv
module winreg_storage #(
  parameter int DATA_W = 32,
  parameter int NREGS  = 136,
  localparam int PHYS_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PHYS_W-1:0] ra_phys,
  output logic [DATA_W-1:0] ra_data,
  input  logic [PHYS_W-1:0] rb_phys,
  output logic [DATA_W-1:0] rb_data,
  input  logic              we,
  input  logic [PHYS_W-1:0] w_phys,
  input  logic [DATA_W-1:0] w_data
);
  logic [DATA_W-1:0] mem [NREGS];
  logic              wr_take;

  assign wr_take = we && (w_phys != '0);   // physical 0 is the zero register

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) mem[i] <= '0;
    end else if (wr_take) begin
      mem[w_phys] <= w_data;
    end
  end

  assign ra_data = (ra_phys == '0) ? '0 : mem[ra_phys];
  assign rb_data = (rb_phys == '0) ? '0 : mem[rb_phys];

  AST_ZERO_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    mem[0] == '0);  // R5
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |=> mem[$past(w_phys)] == $past(w_data));  // R10
endmodule

// File: rtl/winreg_file.sv
module winreg_file
  import winreg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NWIN   = 8,
  localparam int WP_W   = $clog2(NWIN),
  localparam int NREGS  = GRP_SIZE + NWIN * NEW_PER_WIN,
  localparam int PHYS_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [4:0]        rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [4:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              save_req,
  input  logic              restore_req,
  input  logic [NWIN-1:0]   inval_mask,
  output logic [WP_W-1:0]   cur_win,
  output logic              overflow,
  output logic              underflow
);
  localparam int NPORT = 3;   // read A, read B, write

  logic [WP_W-1:0]   cwp;
  logic [ARCH_W-1:0] port_arch [NPORT];
  logic [PHYS_W-1:0] port_phys [NPORT];

  assign port_arch[0] = rd_a_idx;
  assign port_arch[1] = rd_b_idx;
  assign port_arch[2] = wr_idx;

  winreg_win_ctl #(.NWIN(NWIN)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .save_req(save_req), .restore_req(restore_req), .inval_mask(inval_mask),
    .cwp(cwp), .overflow(overflow), .underflow(underflow)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    winreg_addr_map #(.NWIN(NWIN)) u_map (
      .win(cwp), .arch(port_arch[p]), .phys(port_phys[p])
    );
  end

  winreg_storage #(.DATA_W(DATA_W), .NREGS(NREGS)) u_store (
    .clk(clk), .rst_n(rst_n),
    .ra_phys(port_phys[0]), .ra_data(rd_a_data),
    .rb_phys(port_phys[1]), .rb_data(rd_b_data),
    .we(wr_en), .w_phys(port_phys[2]), .w_data(wr_data)
  );

  assign cur_win = cwp;

  AST_ZERO_READ_A: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == 5'd0) |-> rd_a_data == '0);  // R5
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(overflow && underflow));  // R9
endmodule

// File: tb/winreg_file_bench.sv
`timescale 1ns/1ps
module winreg_file_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [31:0] rd_a_data, rd_b_data, wr_data;
  logic        wr_en, save_req, restore_req;
  logic [7:0]  inval_mask;
  logic [2:0]  cur_win;
  logic        overflow, underflow;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  winreg_file u_winreg_file (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .save_req(save_req), .restore_req(restore_req), .inval_mask(inval_mask),
    .cur_win(cur_win), .overflow(overflow), .underflow(underflow)
  );

  // Vector layout: {req[3:0], op[2:0], idx[4:0], data[31:0]}
  localparam logic [2:0] OP_W = 3'd0, OP_RA = 3'd1, OP_RB = 3'd2,
                         OP_SV = 3'd3, OP_RS = 3'd4, OP_CW = 3'd5;
  localparam int NVEC = 21;
  localparam logic [43:0] VEC [NVEC] = '{
    {4'd2,  OP_W,  5'd9,  32'h1111_1111},  // out1 of window 0
    {4'd3,  OP_W,  5'd17, 32'h2222_2222},  // local1 of window 0
    {4'd4,  OP_W,  5'd25, 32'h3333_3333},  // in1 of window 0
    {4'd2,  OP_W,  5'd1,  32'h4444_4444},  // global 1
    {4'd6,  OP_SV, 5'd0,  32'h0},
    {4'd6,  OP_CW, 5'd0,  32'd7},          // R6 wrap 0 -> 7
    {4'd4,  OP_RA, 5'd25, 32'h1111_1111},  // R4 ins(7) == outs(0)
    {4'd3,  OP_RA, 5'd17, 32'h0},          // R3 fresh locals
    {4'd2,  OP_RB, 5'd1,  32'h4444_4444},  // R2 global seen
    {4'd3,  OP_W,  5'd17, 32'h5555_5555},
    {4'd6,  OP_RS, 5'd0,  32'h0},
    {4'd6,  OP_CW, 5'd0,  32'd0},
    {4'd3,  OP_RA, 5'd17, 32'h2222_2222},  // R3 caller locals kept
    {4'd4,  OP_RB, 5'd9,  32'h1111_1111},
    {4'd4,  OP_RA, 5'd25, 32'h3333_3333},
    {4'd6,  OP_RS, 5'd0,  32'h0},
    {4'd6,  OP_CW, 5'd0,  32'd1},          // R6 restore 0 -> 1
    {4'd4,  OP_RB, 5'd9,  32'h3333_3333},  // R4 outs(1) == ins(0)
    {4'd2,  OP_RB, 5'd1,  32'h4444_4444},
    {4'd5,  OP_W,  5'd0,  32'hDEAD_BEEF},
    {4'd5,  OP_RA, 5'd0,  32'h0}           // R5 zero register
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // All drives start at a falling edge; clocked ops complete after the rising edge.
  task automatic clocked_op(input logic w, input logic [4:0] i, input logic [31:0] d,
                            input logic sv, input logic rs);
    @(negedge clk);
    wr_en = w; wr_idx = i; wr_data = d; save_req = sv; restore_req = rs;
    @(posedge clk); #1;
    wr_en = 1'b0; save_req = 1'b0; restore_req = 1'b0;
  endtask

  task automatic read_a(input logic [4:0] i, output logic [31:0] d);
    @(negedge clk); rd_a_idx = i; #1; d = rd_a_data;
  endtask

  logic [31:0] got;

  initial begin
    rst_n = 1'b0; rd_a_idx = '0; rd_b_idx = '0; wr_idx = '0; wr_data = '0;
    wr_en = 1'b0; save_req = 1'b0; restore_req = 1'b0; inval_mask = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    check("R1 cwp", 32'(cur_win), 32'd0);
    check("R1 flags", {30'b0, overflow, underflow}, 32'd0);
    rd_a_idx = 5'd17; rd_b_idx = 5'd30; #1;
    check("R1 rdA", rd_a_data, 32'd0);
    check("R1 rdB", rd_b_data, 32'd0);

    // Table pass
    for (int v = 0; v < NVEC; v++) begin
      logic [3:0]  rq;
      logic [2:0]  op;
      logic [4:0]  ix;
      logic [31:0] dt;
      string       tag;
      {rq, op, ix, dt} = VEC[v];
      tag = $sformatf("R%0d vec%0d", rq, v);
      case (op)
        OP_W:  clocked_op(1'b1, ix, dt, 1'b0, 1'b0);
        OP_SV: clocked_op(1'b0, 5'd0, 32'd0, 1'b1, 1'b0);
        OP_RS: clocked_op(1'b0, 5'd0, 32'd0, 1'b0, 1'b1);
        OP_RA: begin @(negedge clk); rd_a_idx = ix; #1; check(tag, rd_a_data, dt); end
        OP_RB: begin @(negedge clk); rd_b_idx = ix; #1; check(tag, rd_b_data, dt); end
        default: begin @(negedge clk); check(tag, 32'(cur_win), dt); end
      endcase
    end

    // R6 full lap: eight saves from window 1 come back to window 1
    for (int k = 0; k < 8; k++) clocked_op(1'b0, 5'd0, 32'd0, 1'b1, 1'b0);
    @(negedge clk); check("R6 lap", 32'(cur_win), 32'd1);

    // R10 combinational read shows the old value until the edge
    @(negedge clk);
    rd_a_idx = 5'd20; wr_en = 1'b1; wr_idx = 5'd20; wr_data = 32'hABCD_0001; #1;
    check("R10 before edge", rd_a_data, 32'd0);
    @(posedge clk); #1 wr_en = 1'b0;
    @(negedge clk); check("R10 after edge", rd_a_data, 32'hABCD_0001);

    // R10 write in same cycle as save lands in the old window (1)
    clocked_op(1'b1, 5'd21, 32'h0BAD_F00D, 1'b1, 1'b0);      // cwp 1 -> 0
    read_a(5'd21, got); check("R10 new win", got, 32'h0);
    clocked_op(1'b0, 5'd0, 32'd0, 1'b0, 1'b1);               // back to 1
    read_a(5'd21, got); check("R10 old win", got, 32'h0BAD_F00D);

    // R7 overflow: at window 1 the save target is 0
    @(negedge clk);
    inval_mask = 8'b0000_0001; save_req = 1'b1; #1;
    check("R7 flag", {31'b0, overflow}, 32'd1);
    check("R7 no unf", {31'b0, underflow}, 32'd0);
    @(posedge clk); #1 save_req = 1'b0;
    @(negedge clk);
    check("R7 held", 32'(cur_win), 32'd1);
    check("R7 drop", {31'b0, overflow}, 32'd0);

    // R8 underflow: restore target is 2
    @(negedge clk);
    inval_mask = 8'b0000_0100; restore_req = 1'b1; #1;
    check("R8 flag", {31'b0, underflow}, 32'd1);
    @(posedge clk); #1 restore_req = 1'b0;
    @(negedge clk); check("R8 held", 32'(cur_win), 32'd1);

    // R9 both strobes: save wins even though the restore target is masked
    @(negedge clk);
    save_req = 1'b1; restore_req = 1'b1; #1;
    check("R9 no unf", {31'b0, underflow}, 32'd0);
    @(posedge clk); #1 save_req = 1'b0; restore_req = 1'b0;
    @(negedge clk); check("R9 saved", 32'(cur_win), 32'd0);

    // R2 global visible from window 0 too; R5 zero via port B
    inval_mask = '0;
    rd_b_idx = 5'd1; #1; check("R2 win0", rd_b_data, 32'h4444_4444);
    rd_b_idx = 5'd0; #1; check("R5 portB", rd_b_data, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule